// File: doc/BRIEF.md
# Partitioned 8x16 Fractional Multiplier

This block multiplies unsigned 8-bit pixel components by signed 16-bit coefficients in up to four parallel lanes. Each lane forms the full signed product and keeps the middle sixteen bits, bits [23:8], as a fixed-point result. One is added to it when product bit 7 is set, which rounds half up. The sum wraps inside its own 16-bit lane.

A 9-bit operation code picks one of seven variants. They differ in three ways: where each pixel byte is taken from, whether one coefficient is broadcast to every lane, and whether only two lanes run with widened placement in the output. Two 64-bit source words and the code are presented together with a valid strobe. The result, a valid flag and an error flag for unrecognised codes appear on registered outputs one clock later.

Top module: `pmul8x16_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, `out_result` keeps its last value.
- R2: Each lane computes `p = pix * coef`, with `pix` unsigned 8-bit and `coef` signed 16-bit. The lane value is `p[23:8] + p[7]`, and zero pixels give zero results.
- R3: Code 0x031: lane i (0..3) uses pixel `src_a[8i+7:8i]` and coefficient `src_b[16i+15:16i]`, and writes `out_result[16i+15:16i]`.
- R4: Codes 0x033 and 0x035: lane i uses pixel `src_a[8i+7:8i]`. Every lane uses the same coefficient, `src_b[31:16]` for 0x033 and `src_b[15:0]` for 0x035. Lane i writes `out_result[16i+15:16i]`.
- R5: Codes 0x036 and 0x037: lane i uses coefficient `src_b[16i+15:16i]`. Its pixel is `src_a[16i+15:16i+8]` for 0x036 and `src_a[16i+7:16i]` for 0x037. Lane i writes `out_result[16i+15:16i]`.
- R6: Codes 0x038 and 0x039: only lanes 0 and 1 run, with pixels chosen as in R5 (upper byte for 0x038, lower byte for 0x039). Lane j is placed at `out_result[32j+22:32j+7]`, and every other result bit is zero.
- R7: Any other code sets `out_err` together with `out_valid` and gives an all-zero result. A recognised code leaves `out_err` low.
- R8: While `rst` is high at a clock edge, `out_valid`, `out_err` and `out_result` clear to zero.
- R9: A rounding increment that overflows a lane wraps to 0x0000 inside that lane and never changes a neighbouring lane. For example, pixel 1 with coefficient 0xFFFF gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| opcode | input | 9 | Operation code selecting the variant |
| src_a | input | 64 | Pixel source word |
| src_b | input | 64 | Coefficient source word |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 64 | Registered packed result |
| out_err | output | 1 | Registered unrecognised-code flag |

## Verification
The properties assume that `opcode`, `src_a` and `src_b` hold known values whenever `in_valid` is high at a rising edge. They also assume that `rst` is sampled synchronously. The bench changes every input on the falling edge only, so each rising edge sees settled values. The bench also drives random, fully defined operand words in idle cycles, so the hold property is checked against changing inputs and not against constants.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    localparam int unsigned PM_OPC_W  = 9;
    localparam int unsigned PM_LANES  = 4;
    localparam int unsigned PM_PIX_W  = 8;
    localparam int unsigned PM_COEF_W = 16;
    localparam int unsigned PM_SRC_W  = 64;

    typedef enum logic [PM_OPC_W-1:0] {
        OP_MUL_PACKED   = 9'h031,
        OP_MUL_BCAST_HI = 9'h033,
        OP_MUL_BCAST_LO = 9'h035,
        OP_MUL_BYTE_HI  = 9'h036,
        OP_MUL_BYTE_LO  = 9'h037,
        OP_MULW_BYTE_HI = 9'h038,
        OP_MULW_BYTE_LO = 9'h039
    } pmul_op_e;

    // Where each lane's 8-bit pixel is taken from
    typedef enum logic [1:0] {
        PIX_PACKED = 2'd0,
        PIX_HIGH   = 2'd1,
        PIX_LOW    = 2'd2
    } pix_src_e;

    // Where each lane's 16-bit coefficient is taken from
    typedef enum logic [1:0] {
        COEF_PER_LANE = 2'd0,
        COEF_BCAST_HI = 2'd1,
        COEF_BCAST_LO = 2'd2
    } coef_src_e;

    typedef struct packed {
        logic      legal;
        pix_src_e  pix;
        coef_src_e coef;
        logic      widen;
    } pmul_ctrl_t;

    function automatic pmul_ctrl_t pmul_decode(input logic [PM_OPC_W-1:0] op);
        pmul_ctrl_t c;
        c.legal = 1'b0;
        c.pix   = PIX_PACKED;
        c.coef  = COEF_PER_LANE;
        c.widen = 1'b0;
        case (op)
            OP_MUL_PACKED: begin
                c.legal = 1'b1;
            end
            OP_MUL_BCAST_HI: begin
                c.legal = 1'b1;
                c.coef  = COEF_BCAST_HI;
            end
            OP_MUL_BCAST_LO: begin
                c.legal = 1'b1;
                c.coef  = COEF_BCAST_LO;
            end
            OP_MUL_BYTE_HI: begin
                c.legal = 1'b1;
                c.pix   = PIX_HIGH;
            end
            OP_MUL_BYTE_LO: begin
                c.legal = 1'b1;
                c.pix   = PIX_LOW;
            end
            OP_MULW_BYTE_HI: begin
                c.legal = 1'b1;
                c.pix   = PIX_HIGH;
                c.widen = 1'b1;
            end
            OP_MULW_BYTE_LO: begin
                c.legal = 1'b1;
                c.pix   = PIX_LOW;
                c.widen = 1'b1;
            end
            default: begin
                c.legal = 1'b0;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pmul_operand_sel.sv
module pmul_operand_sel
    import pmul_pkg::*;
#(
    parameter int unsigned LANES  = PM_LANES,
    parameter int unsigned PIX_W  = PM_PIX_W,
    parameter int unsigned COEF_W = PM_COEF_W,
    parameter int unsigned SRC_W  = PM_SRC_W
) (
    input  pix_src_e                      pix_src,
    input  coef_src_e                     coef_src,
    input  logic [SRC_W-1:0]              src_a,
    input  logic [SRC_W-1:0]              src_b,
    output logic [LANES-1:0][PIX_W-1:0]   lane_pix,
    output logic [LANES-1:0][COEF_W-1:0]  lane_coef
);

    localparam int unsigned LANE_W = SRC_W / LANES;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            case (pix_src)
                PIX_HIGH: lane_pix[i] = src_a[i*LANE_W + PIX_W +: PIX_W];
                PIX_LOW:  lane_pix[i] = src_a[i*LANE_W +: PIX_W];
                default:  lane_pix[i] = src_a[i*PIX_W +: PIX_W];
            endcase
        end

        always_comb begin
            case (coef_src)
                COEF_BCAST_HI: lane_coef[i] = src_b[COEF_W +: COEF_W];
                COEF_BCAST_LO: lane_coef[i] = src_b[0 +: COEF_W];
                default:       lane_coef[i] = src_b[i*COEF_W +: COEF_W];
            endcase
        end
    end

endmodule

// File: rtl/pmul_lane.sv
module pmul_lane
    import pmul_pkg::*;
#(
    parameter int unsigned PIX_W  = PM_PIX_W,
    parameter int unsigned COEF_W = PM_COEF_W
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic [COEF_W-1:0] coef,
    output logic [COEF_W-1:0] rounded
);

    localparam int unsigned PROD_W = PIX_W + COEF_W + 1;

    logic signed [PROD_W-1:0] pix_ext;
    logic signed [PROD_W-1:0] coef_ext;
    logic signed [PROD_W-1:0] prod;
    logic [COEF_W-1:0]        kept;
    logic                     lane_unused;

    assign pix_ext  = {{(PROD_W-PIX_W){1'b0}}, pix};
    assign coef_ext = {{(PROD_W-COEF_W){coef[COEF_W-1]}}, coef};
    assign prod     = pix_ext * coef_ext;

    // Keep the middle field, round half up on the bit below it; wraps in-lane
    assign kept    = prod[PIX_W+COEF_W-1:PIX_W];
    assign rounded = kept + {{(COEF_W-1){1'b0}}, prod[PIX_W-1]};

    assign lane_unused = ^{prod[PROD_W-1], prod[PIX_W-2:0]};

endmodule

// File: rtl/pmul_pack.sv
module pmul_pack
    import pmul_pkg::*;
#(
    parameter int unsigned LANES    = PM_LANES,
    parameter int unsigned COEF_W   = PM_COEF_W,
    parameter int unsigned SRC_W    = PM_SRC_W,
    parameter int unsigned WIDE_OFS = PM_PIX_W - 1
) (
    input  logic                          legal,
    input  logic                          widen,
    input  logic [LANES-1:0][COEF_W-1:0]  lane_res,
    output logic [SRC_W-1:0]              result
);

    localparam int unsigned HALF_W     = SRC_W / 2;
    localparam int unsigned WIDE_LANES = 2;

    always_comb begin
        result = '0;
        if (legal) begin
            if (widen) begin
                for (int j = 0; j < WIDE_LANES; j++) begin
                    result[j*HALF_W + WIDE_OFS +: COEF_W] = lane_res[j];
                end
            end else begin
                for (int i = 0; i < LANES; i++) begin
                    result[i*COEF_W +: COEF_W] = lane_res[i];
                end
            end
        end
    end

endmodule

// File: rtl/pmul8x16_unit.sv
module pmul8x16_unit
    import pmul_pkg::*;
#(
    parameter int unsigned LANES  = PM_LANES,
    parameter int unsigned PIX_W  = PM_PIX_W,
    parameter int unsigned COEF_W = PM_COEF_W,
    parameter int unsigned SRC_W  = PM_SRC_W,
    parameter int unsigned OPC_W  = PM_OPC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic [SRC_W-1:0] src_a,
    input  logic [SRC_W-1:0] src_b,
    output logic             out_valid,
    output logic [SRC_W-1:0] out_result,
    output logic             out_err
);

    pmul_ctrl_t                  ctrl;
    logic [LANES-1:0][PIX_W-1:0]  lane_pix;
    logic [LANES-1:0][COEF_W-1:0] lane_coef;
    logic [LANES-1:0][COEF_W-1:0] lane_res;
    logic [SRC_W-1:0]             packed_res;

    assign ctrl = pmul_decode(opcode);

    pmul_operand_sel #(
        .LANES (LANES),
        .PIX_W (PIX_W),
        .COEF_W(COEF_W),
        .SRC_W (SRC_W)
    ) u_sel (
        .pix_src  (ctrl.pix),
        .coef_src (ctrl.coef),
        .src_a    (src_a),
        .src_b    (src_b),
        .lane_pix (lane_pix),
        .lane_coef(lane_coef)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_mul
        pmul_lane #(
            .PIX_W (PIX_W),
            .COEF_W(COEF_W)
        ) u_lane (
            .pix    (lane_pix[i]),
            .coef   (lane_coef[i]),
            .rounded(lane_res[i])
        );
    end

    pmul_pack #(
        .LANES   (LANES),
        .COEF_W  (COEF_W),
        .SRC_W   (SRC_W),
        .WIDE_OFS(PIX_W - 1)
    ) u_pack (
        .legal   (ctrl.legal),
        .widen   (ctrl.widen),
        .lane_res(lane_res),
        .result  (packed_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_err    <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            out_err   <= in_valid & ~ctrl.legal;
            if (in_valid) begin
                out_result <= packed_res;
            end
        end
    end

endmodule

// File: rtl/pmul8x16_unit_chk.sv
module pmul8x16_unit_chk
    import pmul_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [PM_OPC_W-1:0] opcode,
    input logic [PM_SRC_W-1:0] src_a,
    input logic [PM_SRC_W-1:0] src_b,
    input logic                out_valid,
    input logic [PM_SRC_W-1:0] out_result,
    input logic                out_err
);

    logic chk_unused;
    assign chk_unused = ^src_b;

    // R1: a valid input is answered on the next cycle
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1: idle input produces no valid and holds the result
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));

    // R2: zero pixels give a zero result for every code
    assert_zero_pix_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_a == '0) |=> (out_result == '0));

    // R6: widened forms leave every bit outside both placed fields at zero
    assert_wide_gaps_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (opcode == 9'h038 || opcode == 9'h039)) |=>
        (out_result[6:0] == '0 && out_result[38:23] == '0 && out_result[63:55] == '0));

    // R7: error only with valid, and always with a zero result
    assert_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_valid && out_result == '0));

    // R7: a recognised code never flags an error
    assert_legal_no_err_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode >= 9'h031 && opcode <= 9'h039 && opcode != 9'h032 && opcode != 9'h034)
        |=> !out_err);

endmodule

bind pmul8x16_unit pmul8x16_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .out_result(out_result),
    .out_err   (out_err)
);

// File: tb/pmul8x16_unit_tb.sv
`timescale 1ns/1ps
module pmul8x16_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [8:0]  opcode;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_err;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    logic [63:0] last_res;

    always #2.5 clk = ~clk;

    pmul8x16_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .out_result(out_result),
        .out_err   (out_err)
    );

    function automatic logic [15:0] ref_lane(input logic [7:0] u, input logic [15:0] c);
        int p;
        int q;
        p = int'(u) * int'($signed(c));
        q = (p >>> 8) + ((p >>> 7) & 1);
        return 16'(q);
    endfunction

    function automatic logic [64:0] ref_op(input logic [8:0] op, input logic [63:0] a,
                                           input logic [63:0] b);
        logic [63:0] r;
        logic        e;
        r = '0;
        e = 1'b0;
        case (op)
            9'h031: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[8*i +: 8], b[16*i +: 16]);
            9'h033: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[8*i +: 8], b[31:16]);
            9'h035: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[8*i +: 8], b[15:0]);
            9'h036: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
            9'h037: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
            9'h038: for (int j = 0; j < 2; j++) r[32*j+7 +: 16] = ref_lane(a[16*j+8 +: 8], b[16*j +: 16]);
            9'h039: for (int j = 0; j < 2; j++) r[32*j+7 +: 16] = ref_lane(a[16*j +: 8], b[16*j +: 16]);
            default: e = 1'b1;
        endcase
        return {e, r};
    endfunction

    function automatic string tag_of(input logic [8:0] op);
        case (op)
            9'h031: return "R3";
            9'h033, 9'h035: return "R4";
            9'h036, 9'h037: return "R5";
            9'h038, 9'h039: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; checks at the next falling edge
    task automatic run_op(input logic [8:0] op, input logic [63:0] a, input logic [63:0] b,
                          input string req, input bit keep);
        logic [64:0] ex;
        in_valid = 1'b1;
        opcode   = op;
        src_a    = a;
        src_b    = b;
        ex = ref_op(op, a, b);
        @(negedge clk);
        check(req, {out_valid, out_err, out_result}, {1'b1, ex[64], ex[63:0]});
        last_res = ex[63:0];
        if (!keep) in_valid = 1'b0;
    endtask

    task automatic idle_check();
        in_valid = 1'b0;
        src_a    = {$urandom, $urandom};
        src_b    = {$urandom, $urandom};
        opcode   = 9'h031;
        @(negedge clk);
        check("R1", {out_valid, out_err, out_result}, {1'b0, 1'b0, last_res});
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [8:0] legal_ops [7];
        logic [8:0] bad_ops [5];
        void'($urandom(32'd20240611));
        legal_ops = '{9'h031, 9'h033, 9'h035, 9'h036, 9'h037, 9'h038, 9'h039};
        bad_ops   = '{9'h030, 9'h034, 9'h03a, 9'h000, 9'h1ff};

        rst      = 1'b1;
        in_valid = 1'b1;
        opcode   = 9'h031;
        src_a    = 64'hFFFF_FFFF_FFFF_FFFF;
        src_b    = 64'h1234_5678_9ABC_DEF0;
        repeat (3) @(negedge clk);
        check("R8", {out_valid, out_err, out_result}, 66'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8", {out_valid, out_err, out_result}, 66'd0);
        last_res = '0;

        // R9: pixel 1 times -1 rounds to 0x0000 in lane 0; lane 1 must not change
        run_op(9'h031, 64'h0000_0000_0000_FF01, 64'h0000_0000_0123_FFFF, "R9", 1'b0);
        check("R9", {2'b00, out_result}, {2'b00, 48'h0, 16'h0000} | {2'b00, 32'h0, ref_lane(8'hFF, 16'h0123), 16'h0});
        // R2: extremes of the signed coefficient and the rounding bit
        run_op(9'h031, 64'h0000_0000_01FF_80FF, 64'h7FFF_0000_0001_7FFF, "R2", 1'b0);
        check("R2", {2'b00, out_result[15:0]}, {2'b00, 48'h0, 16'h7F7F});
        check("R2", {2'b00, out_result[31:16]}, {2'b00, 48'h0, 16'h0001});
        run_op(9'h031, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_8000, "R2", 1'b0);
        check("R2", {2'b00, out_result[15:0]}, {2'b00, 48'h0, 16'h8080});
        idle_check();
        // R4: broadcast picks a different half for each code
        run_op(9'h033, 64'h0000_0000_4080_C0FF, 64'h0000_0000_0200_0100, "R4", 1'b0);
        run_op(9'h035, 64'h0000_0000_4080_C0FF, 64'h0000_0000_0200_0100, "R4", 1'b0);
        // R5 and R6: byte selection within each 16-bit lane, back to back
        run_op(9'h036, 64'h11FF_22EE_33DD_44CC, 64'hF000_0FFF_8001_7FFF, "R5", 1'b1);
        run_op(9'h037, 64'h11FF_22EE_33DD_44CC, 64'hF000_0FFF_8001_7FFF, "R5", 1'b1);
        run_op(9'h038, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_8000_7FFF, "R6", 1'b1);
        run_op(9'h039, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_8000_7FFF, "R6", 1'b0);
        idle_check();
        // R7: unknown code
        run_op(9'h032, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, "R7", 1'b0);
        idle_check();

        for (int n = 0; n < 400; n++) begin
            logic [8:0] op;
            if ($urandom_range(0, 9) == 0) op = bad_ops[$urandom_range(0, 4)];
            else op = legal_ops[$urandom_range(0, 6)];
            run_op(op, {$urandom, $urandom}, {$urandom, $urandom}, tag_of(op),
                   $urandom_range(0, 1) == 1);
            if ($urandom_range(0, 3) == 0) idle_check();
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule